// File: doc/BRIEF.md
# Output Round-Off and Saturation Stage

This stage takes a stereo pair of wide signed filter results and turns each one into a shorter output word. The word is 24 or 20 bits. A rounding offset is added below the output LSB and the extra low bits are then dropped. The offset is either a fixed half LSB or a pseudo-random value spread evenly over one LSB. A limiter follows the rounding. It pins any result that no longer fits the chosen width to the largest or smallest two's complement value.

The stage takes one sample pair per valid strobe and registers the result one cycle later. The width select and the dither enable are taken together with the sample, so switching them between samples has no effect. The dither generator is a 23-bit linear feedback shift register. It steps once per accepted sample, and both channels use the same offset for that sample.

Top module: `rnd_dither_limit`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid` goes to 0, both output words go to 0, and the dither register is loaded with the seed 23'h4C1D35.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 in the cycle after a cycle with `in_valid` low.
- R3: With `wide_sel` = 1 and `dither_on` = 0, each output equals floor((x + 128) / 256), where x is the signed 32-bit input. The result is a 24-bit two's complement word, so the output LSB sits at input bit 8.
- R4: With `wide_sel` = 0 and `dither_on` = 0, each output equals floor((x + 2048) / 4096). This is a 20-bit two's complement value in bits 19:0, sign-extended into bits 23:20.
- R5: With `dither_on` = 1, the offset is not fixed. It is the top F bits of the dither register taken as an unsigned number, where F is 8 in 24-bit mode and 12 in 20-bit mode. The offset is therefore uniform over 0 to one LSB minus one input step.
- R6: The dither register shifts left once per cycle with `in_valid` high. Its new bit 0 is bit 22 XOR bit 17. It holds in every other cycle. Each sample uses the register value from before that sample's shift.
- R7: A rounded result above the largest value of the selected width gives that largest value: 24'h7FFFFF in 24-bit mode and 24'h07FFFF in 20-bit mode. A result below the smallest value gives the smallest value: 24'h800000 or 24'hF80000.
- R8: In cycles with `in_valid` low, the outputs keep their last values. Changes on `wide_sel`, `dither_on`, `in_left` or `in_right` in those cycles have no effect, and they do not change the dither sequence.
- R9: Each channel is rounded from its own input. Both channels use the same offset in a given sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; loads both channels and steps the dither register |
| in_left | input | 32 | Left channel signed filter result |
| in_right | input | 32 | Right channel signed filter result |
| wide_sel | input | 1 | 1 selects a 24-bit output, 0 selects a 20-bit output |
| dither_on | input | 1 | 1 selects random offset, 0 selects half-LSB offset |
| out_valid | output | 1 | A new word pair is present |
| out_left | output | 24 | Left rounded and limited word |
| out_right | output | 24 | Right rounded and limited word |

## Verification
The bench sweeps inputs a few dozen steps either side of a half-LSB threshold, in all four mode combinations. If the offset were misplaced by one bit, or the shift used the wrong width, samples on the wrong side of the threshold would be off by one LSB. It runs the top 300 positive codes and the bottom 300 negative codes. There, a limiter that wraps instead of clamping would turn full scale into the opposite sign. A design that mixed the 24-bit limits into 20-bit mode would let values past 2^19 through. Idle gaps with changing controls and data are followed by a dithered sample. A generator that stepped in idle cycles, or a mode taken outside the strobe, would produce words different from the bench's own shift-register model.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

    localparam int unsigned RDL_IN_W     = 32;
    localparam int unsigned RDL_WIDE_W   = 24;
    localparam int unsigned RDL_NARROW_W = 20;
    localparam int unsigned RDL_LFSR_W   = 23;
    localparam int unsigned RDL_LFSR_TAP = 18;

    typedef struct packed {
        logic wide;
        logic dither;
    } rdl_mode_t;

    function automatic rdl_mode_t rdl_make_mode(input logic wide, input logic dither);
        rdl_mode_t m;
        m.wide   = wide;
        m.dither = dither;
        return m;
    endfunction

endpackage

// File: rtl/rdl_lfsr.sv
module rdl_lfsr #(
    parameter int unsigned        W      = 23,
    parameter int unsigned        TAP    = 18,
    parameter int unsigned        OUT_W  = 12,
    parameter logic [W-1:0]       SEED   = 23'h4C1D35
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [OUT_W-1:0] top_bits
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (step)
            state_q <= {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};
    end

    assign top_bits = state_q[W-1 -: OUT_W];
endmodule

// File: rtl/rdl_round_sat.sv
module rdl_round_sat
    import rdl_pkg::*;
#(
    parameter int unsigned IN_W     = 32,
    parameter int unsigned WIDE_W   = 24,
    parameter int unsigned NARROW_W = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  rdl_mode_t              mode,
    input  logic [IN_W-1:0]        din,
    input  logic [IN_W-NARROW_W-1:0] rnd,
    output logic [WIDE_W-1:0]      dout
);
    localparam int unsigned FW = IN_W - WIDE_W;
    localparam int unsigned FN = IN_W - NARROW_W;
    localparam int unsigned SW = IN_W + 1;

    localparam logic signed [SW-1:0] W_MAX = {{(SW-WIDE_W+1){1'b0}},   {(WIDE_W-1){1'b1}}};
    localparam logic signed [SW-1:0] W_MIN = {{(SW-WIDE_W+1){1'b1}},   {(WIDE_W-1){1'b0}}};
    localparam logic signed [SW-1:0] N_MAX = {{(SW-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic signed [SW-1:0] N_MIN = {{(SW-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

    localparam logic [WIDE_W-1:0] W_MAX_O = {1'b0, {(WIDE_W-1){1'b1}}};
    localparam logic [WIDE_W-1:0] W_MIN_O = {1'b1, {(WIDE_W-1){1'b0}}};
    localparam logic [WIDE_W-1:0] N_MAX_O = {{(WIDE_W-NARROW_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [WIDE_W-1:0] N_MIN_O = {{(WIDE_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

    logic [FN-1:0]         offset;
    logic signed [SW-1:0]  sum;
    logic signed [SW-1:0]  shifted;
    logic                  over_hi, over_lo;
    logic [WIDE_W-1:0]     word_next;

    always_comb begin
        offset = '0;
        if (mode.dither) begin
            if (mode.wide)
                offset[FW-1:0] = rnd[FN-1 -: FW];
            else
                offset = rnd;
        end else begin
            if (mode.wide)
                offset[FW-1] = 1'b1;
            else
                offset[FN-1] = 1'b1;
        end
    end

    always_comb begin
        sum     = $signed({din[IN_W-1], din}) + $signed({{(SW-FN){1'b0}}, offset});
        shifted = mode.wide ? (sum >>> FW) : (sum >>> FN);
        over_hi = mode.wide ? (shifted > W_MAX) : (shifted > N_MAX);
        over_lo = mode.wide ? (shifted < W_MIN) : (shifted < N_MIN);
        if (over_hi)
            word_next = mode.wide ? W_MAX_O : N_MAX_O;
        else if (over_lo)
            word_next = mode.wide ? W_MIN_O : N_MIN_O;
        else
            word_next = shifted[WIDE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            dout <= '0;
        else if (load)
            dout <= word_next;
    end
endmodule

// File: rtl/rnd_dither_limit.sv
module rnd_dither_limit
    import rdl_pkg::*;
#(
    parameter int unsigned           IN_W      = RDL_IN_W,
    parameter int unsigned           WIDE_W    = RDL_WIDE_W,
    parameter int unsigned           NARROW_W  = RDL_NARROW_W,
    parameter int unsigned           LFSR_W    = RDL_LFSR_W,
    parameter int unsigned           LFSR_TAP  = RDL_LFSR_TAP,
    parameter logic [LFSR_W-1:0]     LFSR_SEED = 23'h4C1D35
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_left,
    input  logic [IN_W-1:0]   in_right,
    input  logic              wide_sel,
    input  logic              dither_on,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_left,
    output logic [WIDE_W-1:0] out_right
);
    localparam int unsigned NCH = 2;
    localparam int unsigned RW  = IN_W - NARROW_W;

    rdl_mode_t              mode;
    logic [RW-1:0]          rnd;
    logic [IN_W-1:0]        ch_in  [NCH];
    logic [WIDE_W-1:0]      ch_out [NCH];

    assign mode     = rdl_make_mode(wide_sel, dither_on);
    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    rdl_lfsr #(
        .W     (LFSR_W),
        .TAP   (LFSR_TAP),
        .OUT_W (RW),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk      (clk),
        .rst      (rst),
        .step     (in_valid),
        .top_bits (rnd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rdl_round_sat #(
            .IN_W     (IN_W),
            .WIDE_W   (WIDE_W),
            .NARROW_W (NARROW_W)
        ) u_rs (
            .clk  (clk),
            .rst  (rst),
            .load (in_valid),
            .mode (mode),
            .din  (ch_in[c]),
            .rnd  (rnd),
            .dout (ch_out[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];
endmodule

// File: rtl/rdl_checker.sv
module rdl_checker #(
    parameter int unsigned IN_W   = 32,
    parameter int unsigned WIDE_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [IN_W-1:0]   in_left,
    input logic [IN_W-1:0]   in_right,
    input logic              wide_sel,
    input logic              dither_on,
    input logic              out_valid,
    input logic [WIDE_W-1:0] out_left,
    input logic [WIDE_W-1:0] out_right
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_left) && $stable(out_right))); // R8
    AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide_sel) |=>
        ($countones(out_left[23:19]) == 0 || $countones(out_left[23:19]) == 5)); // R4
    AST_POS_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_right == 32'h7FFFFFFF) |=>
        (out_right == ($past(wide_sel) ? 24'h7FFFFF : 24'h07FFFF))); // R7
    AST_NEG_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_left == 32'h80000000) |=>
        (out_left == ($past(wide_sel) ? 24'h800000 : 24'hF80000))); // R7
    AST_DITHER_SHARED_SIGN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_left == in_right) |=> (out_left == out_right)); // R9
    logic unused_ok;
    assign unused_ok = dither_on;
endmodule

bind rnd_dither_limit rdl_checker #(.IN_W(32), .WIDE_W(24)) u_chk (.*);

// File: tb/rnd_dither_limit_test.sv
module rnd_dither_limit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_left = '0;
    logic [31:0] in_right = '0;
    logic        wide_sel = 1'b0;
    logic        dither_on = 1'b0;
    logic        out_valid;
    logic [23:0] out_left;
    logic [23:0] out_right;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [22:0] model_lfsr = 23'h4C1D35;

    always #5 clk = ~clk;

    rnd_dither_limit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
        .wide_sel(wide_sel), .dither_on(dither_on), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] expect_word(input logic [31:0] x, input bit w, input bit d,
                                                input logic [22:0] st);
        int    f   = w ? 8 : 12;
        longint xv = longint'($signed(x));
        longint off = d ? longint'(st >> (23 - f)) : (longint'(1) << (f - 1));
        longint q  = (xv + off) >>> f;
        longint mx = (longint'(1) << (w ? 23 : 19)) - 1;
        longint mn = -mx - 1;
        if (q > mx) q = mx;
        if (q < mn) q = mn;
        return 24'(q);
    endfunction

    function automatic logic [22:0] lfsr_next(input logic [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    logic [23:0] last_l, last_r;

    task automatic send(input logic [31:0] xl, input logic [31:0] xr, input bit w, input bit d,
                        input string tag);
        logic [23:0] el, er;
        el = expect_word(xl, w, d, model_lfsr);
        er = expect_word(xr, w, d, model_lfsr);
        @(negedge clk);
        in_valid = 1'b1; in_left = xl; in_right = xr; wide_sel = w; dither_on = d;
        @(negedge clk);
        in_valid = 1'b0;
        model_lfsr = lfsr_next(model_lfsr);
        check("R2 out_valid", {23'd0, out_valid}, 24'd1);
        check(tag, out_left, el);
        check("R9 right channel", out_right, er);
        last_l = el; last_r = er;
    endtask

    function automatic string mode_tag(input bit w, input bit d);
        if (d) return "R5 dither offset";
        return w ? "R3 24-bit round" : "R4 20-bit round";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {23'd0, out_valid}, 24'd0);
        check("R1 reset left", out_left, 24'd0);
        check("R1 reset right", out_right, 24'd0);
        rst = 1'b0;

        // R6: first dithered sample uses the seed itself
        send(32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, "R6 seed offset");

        for (int m = 0; m < 4; m++) begin
            bit w = m[0];
            bit d = m[1];
            int f = w ? 8 : 12;
            for (int k = -3; k <= 3; k++) begin
                for (int i = -24; i <= 24; i++) begin
                    logic [31:0] x;
                    x = 32'((k * 977) <<< f) + 32'(1 << (f - 1)) + 32'(i);
                    send(x, 32'(-$signed(x)), w, d, mode_tag(w, d));
                end
            end
        end

        for (int m = 0; m < 4; m++) begin
            bit w = m[0];
            bit d = m[1];
            for (int i = 0; i < 300; i++) begin
                send(32'h7FFF_FFFF - 32'(i), 32'h8000_0000 + 32'(i), w, d, "R7 limiter");
            end
        end

        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            send(r, $urandom, i[0], i[1], mode_tag(i[0], i[1]));
        end

        for (int g = 0; g < 20; g++) begin
            send($urandom, $urandom, 1'b1, 1'b1, "R5 dither offset");
            @(negedge clk);
            wide_sel = 1'b0; dither_on = 1'b0; in_left = $urandom; in_right = $urandom;
            repeat (3) @(negedge clk);
            check("R8 hold left", out_left, last_l);
            check("R8 hold right", out_right, last_r);
            check("R2 idle valid", {23'd0, out_valid}, 24'd0);
            send($urandom, $urandom, g[0], 1'b1, "R6 no step when idle");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule